// File: doc/BRIEF.md
# SD Host Interrupt Event Unit

This unit gathers the interrupt events of an SD card host controller and turns them into an interrupt line for the CPU. The command path, data path and card-detect logic deliver single-cycle event pulses. Each pulse sets a sticky bit in a 32-bit event status register. A 32-bit mask register selects which events may raise the interrupt. The CPU reaches both registers through a 16-bit register port, one half at a time. It acknowledges an event by writing a zero to that bit. The interrupt output is active low, so the host can detect its falling edge.

A second, 16-bit status and mask pair collects SDIO card events. These events drive their own active-low line. That line is gated by an enable bit in a transaction-control register. A read of the low status half also shows the live write-protect level of the card. That bit is not sticky and never raises an interrupt. Reads have no side effects.

Top module: `sd_irq_ctrl`

## Requirements
- R1: After reset, every event status bit is 0 and every mask bit is 1. The SDIO enable is 0, and both `irq_n` and `sdio_irq_n` are 1.
- R2: A pulse on an implemented event bit sets that status bit, and the bit stays set until it is cleared. The implemented main bits are 0 (response end), 2 (transfer end), 3 (card removed), 4 (card inserted), 17 (CRC fail), 19 (data timeout), 22 (command timeout), 24 (receive overflow), 25 (transmit underrun), 26 (receive ready) and 27 (transmit request). Pulses on any other bit are ignored, and those bits read 0.
- R3: A status write clears each bit written as 0 and keeps each bit written as 1. Byte offset 0x1C holds bits 15:0 and offset 0x1E holds bits 31:16. A write to one half leaves the other half unchanged.
- R4: If an event pulse arrives in the same cycle as a write that clears its bit, the bit stays set.
- R5: `irq_n` is 0 exactly when (status AND implemented set AND NOT mask) is non-zero. It follows that condition one clock after the status or mask register changes.
- R6: The mask is read and written as two halves, bits 15:0 at 0x20 and bits 31:16 at 0x22. All 32 bits read back as written. A mask bit of 1 blocks its event and a mask bit of 0 passes it.
- R7: Bit 7 of a read at 0x1C returns the live `card_wp` level. Writes do not clear it, and it never raises `irq_n`.
- R8: The SDIO status register is at 0x36 and its mask at 0x38. They use the same sticky, write-0-to-clear and mask-1-blocks rules as the main registers. The implemented SDIO bits are 0 (card IO interrupt), 1, 2, 14 and 15. Pulses on other bits are ignored.
- R9: Bit 0 of the transaction-control register at 0x34 is the SDIO enable, and the other bits read 0. `sdio_irq_n` is 0 exactly when the enable is 1 and some unmasked implemented SDIO status bit is set. It is registered one clock after the condition changes.
- R10: Reads change no state. A write to an unmapped offset changes nothing, and a read from an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 9 | Byte offset of the 16-bit register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| evt_pulse | input | 32 | Main event pulses, one bit per status bit |
| sdio_evt_pulse | input | 16 | SDIO event pulses |
| card_wp | input | 1 | Live write-protect level of the card |
| irq_n | output | 1 | Main interrupt, active low |
| sdio_irq_n | output | 1 | SDIO interrupt, active low |

## Verification
A status bit that is lost or stuck shows up at the next read of its half, and on `irq_n` two clocks after the event if the bit is unmasked. A wrong mask bit or a wrong implemented set changes `irq_n` one clock after the status change. The vectors therefore pair each masked event with an unmasked one and each implemented bit with an unimplemented one. A bad half-word decode corrupts the opposite half, which the vectors read back after every single-half write. The SDIO gate is toggled with the same status held, so an error in the enable path appears on `sdio_irq_n` alone.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

    localparam int ADDR_W   = 9;
    localparam int REG_W    = 16;
    localparam int MAIN_W   = 32;
    localparam int SDIO_W   = 16;
    localparam int MAIN_LN  = MAIN_W / REG_W;
    localparam int SDIO_LN  = SDIO_W / REG_W;

    // Byte offsets of the register halves
    localparam logic [ADDR_W-1:0] OFF_ST_LO   = 9'h01C;
    localparam logic [ADDR_W-1:0] OFF_ST_HI   = 9'h01E;
    localparam logic [ADDR_W-1:0] OFF_MSK_LO  = 9'h020;
    localparam logic [ADDR_W-1:0] OFF_MSK_HI  = 9'h022;
    localparam logic [ADDR_W-1:0] OFF_XCTL    = 9'h034;
    localparam logic [ADDR_W-1:0] OFF_SD_ST   = 9'h036;
    localparam logic [ADDR_W-1:0] OFF_SD_MSK  = 9'h038;

    // Implemented interrupt sources
    localparam logic [MAIN_W-1:0] MAIN_SRC_SET = 32'h0F4A_001D;
    localparam logic [SDIO_W-1:0] SDIO_SRC_SET = 16'hC007;

    // Live write-protect level shown in the low status half
    localparam int WP_BIT = 7;

    typedef struct packed {
        logic [MAIN_LN-1:0] st_wr;
        logic [MAIN_LN-1:0] msk_wr;
        logic [SDIO_LN-1:0] sd_st_wr;
        logic [SDIO_LN-1:0] sd_msk_wr;
        logic               xctl_wr;
    } wr_lanes_t;

endpackage

// File: rtl/isr_sticky_bank.sv
module isr_sticky_bank #(
    parameter int              WIDTH  = 32,
    parameter int              LANE_W = 16,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          set_i,
    input  logic [WIDTH/LANE_W-1:0]   st_wr_i,
    input  logic [WIDTH/LANE_W-1:0]   msk_wr_i,
    input  logic [LANE_W-1:0]         wdata_i,
    output logic [WIDTH-1:0]          status_o,
    output logic [WIDTH-1:0]          mask_o,
    output logic [WIDTH-1:0]          pend_o
);
    localparam int LANES = WIDTH / LANE_W;

    typedef struct packed {
        logic [WIDTH-1:0] st;
        logic [WIDTH-1:0] msk;
    } bank_t;

    bank_t            q, d;
    logic [WIDTH-1:0] keep_d;
    logic [WIDTH-1:0] msk_d;

    always_comb begin
        keep_d = '1;
        msk_d  = q.msk;
        for (int l = 0; l < LANES; l++) begin
            if (st_wr_i[l])  keep_d[l*LANE_W +: LANE_W] = wdata_i;
            if (msk_wr_i[l]) msk_d[l*LANE_W +: LANE_W]  = wdata_i;
        end
        // a fresh event overrides a same-cycle acknowledge
        d.st  = ((q.st & keep_d) | set_i) & IMPL;
        d.msk = msk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= '0;
            q.msk <= '1;
        end else begin
            q <= d;
        end
    end

    assign status_o = q.st;
    assign mask_o   = q.msk;
    assign pend_o   = q.st & IMPL & ~q.msk;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & IMPL)) |=> ((q.st & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R4

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st & ~$past(q.st) & ~$past(set_i)) == '0)); // R2

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.st) & ~q.st) != '0) |-> $past(|st_wr_i)); // R10

endmodule

// File: rtl/isr_addr_dec.sv
module isr_addr_dec
    import sd_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [MAIN_W-1:0] main_st_i,
    input  logic [MAIN_W-1:0] main_msk_i,
    input  logic [SDIO_W-1:0] sd_st_i,
    input  logic [SDIO_W-1:0] sd_msk_i,
    input  logic              xctl_en_i,
    input  logic              wp_i,
    output wr_lanes_t         lanes_o,
    output logic [REG_W-1:0]  rdata_o
);
    always_comb begin
        lanes_o              = '0;
        lanes_o.st_wr[0]     = wr_i && (addr_i == OFF_ST_LO);
        lanes_o.st_wr[1]     = wr_i && (addr_i == OFF_ST_HI);
        lanes_o.msk_wr[0]    = wr_i && (addr_i == OFF_MSK_LO);
        lanes_o.msk_wr[1]    = wr_i && (addr_i == OFF_MSK_HI);
        lanes_o.sd_st_wr[0]  = wr_i && (addr_i == OFF_SD_ST);
        lanes_o.sd_msk_wr[0] = wr_i && (addr_i == OFF_SD_MSK);
        lanes_o.xctl_wr      = wr_i && (addr_i == OFF_XCTL);
    end

    always_comb begin
        case (addr_i)
            OFF_ST_LO:  rdata_o = main_st_i[REG_W-1:0] | (REG_W'(wp_i) << WP_BIT);
            OFF_ST_HI:  rdata_o = main_st_i[MAIN_W-1:REG_W];
            OFF_MSK_LO: rdata_o = main_msk_i[REG_W-1:0];
            OFF_MSK_HI: rdata_o = main_msk_i[MAIN_W-1:REG_W];
            OFF_XCTL:   rdata_o = REG_W'(xctl_en_i);
            OFF_SD_ST:  rdata_o = sd_st_i;
            OFF_SD_MSK: rdata_o = sd_msk_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/isr_irq_drv.sv
module isr_irq_drv #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_any_i,
    output logic [N-1:0] irq_n_o
);
    logic [N-1:0] irq_n_d, irq_n_q;

    always_comb begin
        irq_n_d = ~pend_any_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n_q <= '1;
        else        irq_n_q <= irq_n_d;
    end

    assign irq_n_o = irq_n_q;
endmodule

// File: rtl/sd_irq_ctrl.sv
module sd_irq_ctrl
    import sd_irq_pkg::*;
#(
    parameter logic [MAIN_W-1:0] MAIN_SET = MAIN_SRC_SET,
    parameter logic [SDIO_W-1:0] SDIO_SET = SDIO_SRC_SET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [MAIN_W-1:0] evt_pulse,
    input  logic [SDIO_W-1:0] sdio_evt_pulse,
    input  logic              card_wp,
    output logic              irq_n,
    output logic              sdio_irq_n
);
    typedef struct packed {
        logic sdio_en;
    } xctl_t;

    wr_lanes_t         lanes;
    logic [MAIN_W-1:0] main_st, main_msk, main_pend;
    logic [SDIO_W-1:0] sd_st, sd_msk, sd_pend;
    xctl_t             xctl_d, xctl_q;
    logic [1:0]        pend_any;
    logic [1:0]        irq_lines_n;

    isr_addr_dec u_dec (
        .addr_i     (reg_addr),
        .wr_i       (reg_wr),
        .main_st_i  (main_st),
        .main_msk_i (main_msk),
        .sd_st_i    (sd_st),
        .sd_msk_i   (sd_msk),
        .xctl_en_i  (xctl_q.sdio_en),
        .wp_i       (card_wp),
        .lanes_o    (lanes),
        .rdata_o    (reg_rdata)
    );

    isr_sticky_bank #(.WIDTH(MAIN_W), .LANE_W(REG_W), .IMPL(MAIN_SET)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_pulse),
        .st_wr_i  (lanes.st_wr),
        .msk_wr_i (lanes.msk_wr),
        .wdata_i  (reg_wdata),
        .status_o (main_st),
        .mask_o   (main_msk),
        .pend_o   (main_pend)
    );

    isr_sticky_bank #(.WIDTH(SDIO_W), .LANE_W(REG_W), .IMPL(SDIO_SET)) u_sdio (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (sdio_evt_pulse),
        .st_wr_i  (lanes.sd_st_wr),
        .msk_wr_i (lanes.sd_msk_wr),
        .wdata_i  (reg_wdata),
        .status_o (sd_st),
        .mask_o   (sd_msk),
        .pend_o   (sd_pend)
    );

    always_comb begin
        xctl_d = xctl_q;
        if (lanes.xctl_wr) xctl_d.sdio_en = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xctl_q <= '0;
        else        xctl_q <= xctl_d;
    end

    assign pend_any[0] = |main_pend;
    assign pend_any[1] = xctl_q.sdio_en && (|sd_pend);

    isr_irq_drv #(.N(2)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any_i (pend_any),
        .irq_n_o    (irq_lines_n)
    );

    assign irq_n      = irq_lines_n[0];
    assign sdio_irq_n = irq_lines_n[1];

    AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !$past(|main_pend)); // R5

    AST_SDIO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xctl_q.sdio_en) |-> sdio_irq_n); // R9

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(main_msk) == '1) |-> irq_n); // R6

endmodule

// File: tb/sd_irq_ctrl_bench.sv
module sd_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [8:0]  waddr;
        logic [15:0] wdata;
        logic [31:0] evt;
        logic [15:0] sevt;
        logic [8:0]  raddr;
        logic [15:0] exp_rd;
        logic        exp_irq;
        logic        exp_sirq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0, 9'h000, 16'h0000, 32'h0000_0000, 16'h0000, 9'h020, 16'hFFFF, 1'b1, 1'b1}, // R1 mask low
        '{4'd1,  1'b0, 9'h000, 16'h0000, 32'h0000_0000, 16'h0000, 9'h022, 16'hFFFF, 1'b1, 1'b1}, // R1 mask high
        '{4'd2,  1'b0, 9'h000, 16'h0000, 32'h0000_0001, 16'h0000, 9'h01C, 16'h0001, 1'b1, 1'b1}, // R2 masked event
        '{4'd6,  1'b1, 9'h020, 16'hFFFE, 32'h0000_0000, 16'h0000, 9'h020, 16'hFFFE, 1'b0, 1'b1}, // R6 unmask bit0
        '{4'd3,  1'b1, 9'h01C, 16'hFFFE, 32'h0000_0000, 16'h0000, 9'h01C, 16'h0000, 1'b1, 1'b1}, // R3 clear bit0
        '{4'd2,  1'b0, 9'h000, 16'h0000, 32'h0400_0000, 16'h0000, 9'h01E, 16'h0400, 1'b1, 1'b1}, // R2 high event
        '{4'd6,  1'b1, 9'h022, 16'hFBFF, 32'h0000_0000, 16'h0000, 9'h022, 16'hFBFF, 1'b0, 1'b1}, // R6 unmask bit26
        '{4'd3,  1'b1, 9'h01C, 16'h0000, 32'h0000_0000, 16'h0000, 9'h01E, 16'h0400, 1'b0, 1'b1}, // R3 other half kept
        '{4'd2,  1'b0, 9'h000, 16'h0000, 32'h0000_0020, 16'h0000, 9'h01C, 16'h0000, 1'b0, 1'b1}, // R2 unimplemented
        '{4'd4,  1'b1, 9'h01E, 16'hFBFF, 32'h0400_0000, 16'h0000, 9'h01E, 16'h0400, 1'b0, 1'b1}, // R4 event wins
        '{4'd3,  1'b1, 9'h01E, 16'hFBFF, 32'h0000_0000, 16'h0000, 9'h01E, 16'h0000, 1'b1, 1'b1}, // R3 clear bit26
        '{4'd6,  1'b1, 9'h020, 16'h0000, 32'h0000_0000, 16'h0000, 9'h020, 16'h0000, 1'b1, 1'b1}, // R6 unmask low
        '{4'd5,  1'b0, 9'h000, 16'h0000, 32'h0000_0002, 16'h0000, 9'h01C, 16'h0000, 1'b1, 1'b1}, // R5 unimpl no irq
        '{4'd5,  1'b0, 9'h000, 16'h0000, 32'h0000_000C, 16'h0000, 9'h01C, 16'h000C, 1'b0, 1'b1}, // R5 two events
        '{4'd3,  1'b1, 9'h01C, 16'hFFFB, 32'h0000_0000, 16'h0000, 9'h01C, 16'h0008, 1'b0, 1'b1}, // R3 partial clear
        '{4'd6,  1'b1, 9'h020, 16'h0008, 32'h0000_0000, 16'h0000, 9'h01C, 16'h0008, 1'b1, 1'b1}, // R6 mask blocks
        '{4'd3,  1'b1, 9'h01C, 16'hFFF7, 32'h0000_0000, 16'h0000, 9'h01C, 16'h0000, 1'b1, 1'b1}, // R3 clear bit3
        '{4'd8,  1'b0, 9'h000, 16'h0000, 32'h0000_0000, 16'h0001, 9'h036, 16'h0001, 1'b1, 1'b1}, // R8 sdio event
        '{4'd8,  1'b1, 9'h038, 16'hFFFE, 32'h0000_0000, 16'h0000, 9'h038, 16'hFFFE, 1'b1, 1'b1}, // R8 sdio unmask
        '{4'd9,  1'b1, 9'h034, 16'hFFFF, 32'h0000_0000, 16'h0000, 9'h034, 16'h0001, 1'b1, 1'b0}, // R9 enable
        '{4'd9,  1'b1, 9'h034, 16'h0000, 32'h0000_0000, 16'h0000, 9'h034, 16'h0000, 1'b1, 1'b1}, // R9 disable
        '{4'd9,  1'b1, 9'h034, 16'h0001, 32'h0000_0000, 16'h0000, 9'h036, 16'h0001, 1'b1, 1'b0}, // R9 re-enable
        '{4'd8,  1'b1, 9'h036, 16'hFFFE, 32'h0000_0000, 16'h0000, 9'h036, 16'h0000, 1'b1, 1'b1}, // R8 sdio clear
        '{4'd8,  1'b0, 9'h000, 16'h0000, 32'h0000_0000, 16'h0008, 9'h036, 16'h0000, 1'b1, 1'b1}, // R8 sdio unimpl
        '{4'd10, 1'b1, 9'h040, 16'hFFFF, 32'h0000_0000, 16'h0000, 9'h040, 16'h0000, 1'b1, 1'b1}, // R10 unmapped
        '{4'd10, 1'b0, 9'h000, 16'h0000, 32'h0000_0000, 16'h0000, 9'h022, 16'hFBFF, 1'b1, 1'b1}  // R10 mask intact
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic [15:0] sdio_evt_pulse = '0;
    logic        card_wp = 1'b0;
    logic        irq_n, sdio_irq_n;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_irq_ctrl u_sd_irq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .evt_pulse      (evt_pulse),
        .sdio_evt_pulse (sdio_evt_pulse),
        .card_wp        (card_wp),
        .irq_n          (irq_n),
        .sdio_irq_n     (sdio_irq_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // one-cycle stimulus, then one idle cycle so the irq register settles
    task automatic apply(input logic wr, input logic [8:0] a, input logic [15:0] wd,
                         input logic [31:0] ev, input logic [15:0] sev);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        evt_pulse = ev; sdio_evt_pulse = sev;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0; sdio_evt_pulse = '0;
        @(negedge clk);
    endtask

    task automatic peek(input logic [8:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        peek(9'h01C); check("R1", "status low", 32'(reg_rdata), 32'h0);
        peek(9'h01E); check("R1", "status high", 32'(reg_rdata), 32'h0);
        peek(9'h034); check("R1", "sdio enable", 32'(reg_rdata), 32'h0);
        check("R1", "irq_n", 32'(irq_n), 32'h1);
        check("R1", "sdio_irq_n", 32'(sdio_irq_n), 32'h1);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            apply(VECS[i].wr, VECS[i].waddr, VECS[i].wdata, VECS[i].evt, VECS[i].sevt);
            peek(VECS[i].raddr);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rdata", i),
                  32'(reg_rdata), 32'(VECS[i].exp_rd));
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d irq_n", i),
                  32'(irq_n), 32'(VECS[i].exp_irq));
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d sdio_irq_n", i),
                  32'(sdio_irq_n), 32'(VECS[i].exp_sirq));
        end

        // R7 live write-protect level, not clearable, no interrupt
        card_wp = 1'b1;
        peek(9'h01C); check("R7", "wp level", 32'(reg_rdata), 32'h0080);
        apply(1'b1, 9'h01C, 16'h0000, '0, '0);
        peek(9'h01C); check("R7", "wp after clear", 32'(reg_rdata), 32'h0080);
        check("R7", "irq_n with wp", 32'(irq_n), 32'h1);
        card_wp = 1'b0;
        peek(9'h01C); check("R7", "wp low", 32'(reg_rdata), 32'h0000);

        // R5 one-cycle latency of irq_n (mask low half is 0x0008)
        @(negedge clk);
        evt_pulse = 32'h1;
        @(negedge clk);
        evt_pulse = '0;
        check("R5", "irq_n before latency", 32'(irq_n), 32'h1);
        @(negedge clk);
        check("R5", "irq_n after latency", 32'(irq_n), 32'h0);
        apply(1'b1, 9'h01C, 16'hFFFE, '0, '0);
        check("R5", "irq_n released", 32'(irq_n), 32'h1);

        // R10 repeated reads leave the state intact
        apply(1'b0, 9'h000, 16'h0000, 32'h4, '0);
        reg_addr = 9'h01C;
        repeat (3) @(negedge clk);
        peek(9'h01C); check("R10", "status after reads", 32'(reg_rdata), 32'h0004);
        check("R10", "irq_n after reads", 32'(irq_n), 32'h0);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        peek(9'h020); check("R1", "mask low after reset", 32'(reg_rdata), 32'hFFFF);
        peek(9'h022); check("R1", "mask high after reset", 32'(reg_rdata), 32'hFFFF);
        peek(9'h01C); check("R1", "status after reset", 32'(reg_rdata), 32'h0);
        peek(9'h034); check("R1", "enable after reset", 32'(reg_rdata), 32'h0);
        check("R1", "irq_n after reset", 32'(irq_n), 32'h1);
        check("R1", "sdio_irq_n after reset", 32'(sdio_irq_n), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule